// File: doc/BRIEF.md
# Input Signal Level Meter

This block measures how strong a wideband sample stream is. It takes 16-bit two's complement samples together with a per-cycle enable, forms each sample's magnitude, and reduces the magnitudes to one 32-bit level figure. A host reads that figure as the input level, for example to steer an analog gain stage ahead of a converter.

The block has two ways of forming the level. In the windowed mode it adds up the magnitudes over a block of samples whose length is programmed. When the block is complete, it publishes the total and starts the next block from zero. In the smoothing mode it runs a first-order recursive average with no window. The weight of the newest sample is a power of two, so the update uses shifts and adders and needs no multiplier.

Top module: `sig_level_meter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `result_o` is 0 and `result_vld_o` is 0, and the block is in windowed mode with an empty window.
- R2: With `mode_i` = 0 (windowed), the block adds the magnitudes of the accepted samples of one window. After the clock edge that takes the last sample of the window, `result_o` shows the total and `result_vld_o` is high for exactly one cycle.
- R3: A window holds `win_len_i` + 2 accepted samples, so the 16-bit field covers lengths 2 through 65537. A full-length window of full-scale samples is reported without overflow.
- R4: Once a window has been reported, the next window starts from a sum of zero. `result_o` holds its value on every cycle in which `result_vld_o` is low.
- R5: The magnitude of the most negative input, -32768, is taken as 32767.
- R6: A cycle with `smp_en_i` low has no effect. It does not change the sum, does not advance the window count and does not alter `result_o`, and `result_vld_o` is low on the following cycle.
- R7: With `mode_i` = 1 (smoothing), each accepted sample x updates the 32-bit state y to y + ((|x|·2^16) >> k) − (y >> k). The new y appears on `result_o` after that clock edge, and the result never exceeds 32767·2^16.
- R8: `leak_sel_i` sets k: code 0 gives k = 0, code 1 gives k = 8, code 2 gives k = 12 and code 3 gives k = 16. With k = 0 the result equals |x|·2^16.
- R9: A change of `mode_i` clears the state and the window count. The sample accepted on the cycle of the change is the first sample of the new mode.
- R10: In smoothing mode `result_vld_o` is high on the cycle after every accepted sample, whatever the value of `win_len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_i | input | 16 | Two's complement input sample |
| smp_en_i | input | 1 | Sample accepted on this cycle when high |
| mode_i | input | 1 | 0 = windowed sum, 1 = smoothing average |
| leak_sel_i | input | 2 | Smoothing shift select (k = 0, 8, 12, 16) |
| win_len_i | input | 16 | Window length minus two |
| result_o | output | 32 | Latest level figure |
| result_vld_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The hardest case to reach is the end of the longest window. Only after 65537 accepted samples does the sum come close to its 32-bit limit and the 17-bit count reach its top. The bench therefore drives one unbroken run of the most negative code at the maximum length setting, which also exercises the saturation of that code. A mode change in the middle of a partly filled window is the other case that is hard to create. The bench switches modes two samples into a window, in both directions. A behavioural model compares `result_o` and `result_vld_o` on every cycle, including during random enable gaps and random shift selections.

// File: rtl/lvlm_pkg.sv
package lvlm_pkg;

    typedef enum logic {
        LVLM_WINDOW = 1'b0,
        LVLM_LEAKY  = 1'b1
    } lvlm_mode_e;

    // Shift amounts selected by leak_sel_i codes 0..3.
    localparam int unsigned LVLM_K0 = 0;
    localparam int unsigned LVLM_K1 = 8;
    localparam int unsigned LVLM_K2 = 12;
    localparam int unsigned LVLM_K3 = 16;

endpackage

// File: rtl/lvlm_mag.sv
// Magnitude of a two's complement sample, saturating the most negative code.
module lvlm_mag #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] x_i,
    output logic        [DW-2:0] mag_o
);
    localparam logic signed [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW-1:0] neg;

    always_comb begin
        neg = -x_i;
        if (x_i == MOST_NEG) begin
            mag_o = {(DW-1){1'b1}};
        end else if (x_i[DW-1]) begin
            mag_o = neg[DW-2:0];
        end else begin
            mag_o = x_i[DW-2:0];
        end
    end
endmodule

// File: rtl/lvlm_leak_step.sv
// One update of the shift-based recursive average.
module lvlm_leak_step #(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic [AW-1:0] y_i,
    input  logic [DW-2:0] mag_i,
    input  logic [1:0]    sel_i,
    output logic [AW-1:0] y_o
);
    import lvlm_pkg::*;

    localparam int FRAC = AW - DW;

    logic [AW-1:0] scaled;
    logic [AW-1:0] add_term;
    logic [AW-1:0] sub_term;

    always_comb begin
        scaled = AW'(mag_i) << FRAC;
        case (sel_i)
            2'd0: begin
                add_term = scaled >> LVLM_K0;
                sub_term = y_i >> LVLM_K0;
            end
            2'd1: begin
                add_term = scaled >> LVLM_K1;
                sub_term = y_i >> LVLM_K1;
            end
            2'd2: begin
                add_term = scaled >> LVLM_K2;
                sub_term = y_i >> LVLM_K2;
            end
            default: begin
                add_term = scaled >> LVLM_K3;
                sub_term = y_i >> LVLM_K3;
            end
        endcase
        y_o = (y_i - sub_term) + add_term;
    end
endmodule

// File: rtl/lvlm_win_ctr.sv
// Counts accepted samples of a window and flags the last one.
module lvlm_win_ctr #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          step_i,
    input  logic [LW-1:0] win_len_i,
    output logic          last_o
);
    localparam int CW = LW + 1;

    logic [CW-1:0] cnt_q, cnt_d, cnt_eff, limit;

    always_comb begin
        cnt_eff = restart_i ? '0 : cnt_q;
        limit   = CW'(win_len_i) + CW'(1);
        last_o  = step_i && (cnt_eff >= limit);
        cnt_d   = cnt_eff;
        if (step_i) begin
            cnt_d = last_o ? '0 : cnt_eff + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sig_level_meter.sv
module sig_level_meter #(
    parameter int DW = 16,
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] smp_i,
    input  logic                 smp_en_i,
    input  logic                 mode_i,
    input  logic [1:0]           leak_sel_i,
    input  logic [LW-1:0]        win_len_i,
    output logic [AW-1:0]        result_o,
    output logic                 result_vld_o
);
    import lvlm_pkg::*;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [AW-1:0] res;
        logic          vld;
        lvlm_mode_e    mode;
    } lvlm_state_t;

    lvlm_state_t s_q, s_d;

    logic [DW-2:0] mag;
    logic [AW-1:0] acc_base;
    logic [AW-1:0] y_nxt;
    logic [AW-1:0] win_sum;
    logic          restart;
    logic          win_step;
    logic          win_last;
    lvlm_mode_e    mode_in;

    lvlm_mag #(.DW(DW)) u_mag (
        .x_i   (smp_i),
        .mag_o (mag)
    );

    lvlm_leak_step #(.AW(AW), .DW(DW)) u_leak (
        .y_i   (acc_base),
        .mag_i (mag),
        .sel_i (leak_sel_i),
        .y_o   (y_nxt)
    );

    lvlm_win_ctr #(.LW(LW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .step_i    (win_step),
        .win_len_i (win_len_i),
        .last_o    (win_last)
    );

    always_comb begin
        mode_in  = lvlm_mode_e'(mode_i);
        restart  = (mode_in != s_q.mode);
        win_step = smp_en_i && (mode_in == LVLM_WINDOW);
        acc_base = restart ? '0 : s_q.acc;
        win_sum  = acc_base + AW'(mag);

        s_d      = s_q;
        s_d.vld  = 1'b0;
        s_d.mode = mode_in;
        s_d.acc  = acc_base;
        if (smp_en_i) begin
            if (mode_in == LVLM_WINDOW) begin
                if (win_last) begin
                    s_d.res = win_sum;
                    s_d.vld = 1'b1;
                    s_d.acc = '0;
                end else begin
                    s_d.acc = win_sum;
                end
            end else begin
                s_d.acc = y_nxt;
                s_d.res = y_nxt;
                s_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{acc: '0, res: '0, vld: 1'b0, mode: LVLM_WINDOW};
        end else begin
            s_q <= s_d;
        end
    end

    assign result_o     = s_q.res;
    assign result_vld_o = s_q.vld;
endmodule

// File: rtl/lvlm_chk.sv
module lvlm_chk #(
    parameter int DW = 16,
    parameter int AW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic signed [DW-1:0] smp_i,
    input logic                 smp_en_i,
    input logic                 mode_i,
    input logic [1:0]           leak_sel_i,
    input logic [AW-1:0]        result_o,
    input logic                 result_vld_o
);
    localparam logic [AW-1:0] Y_CEIL = AW'({(DW-1){1'b1}}) << (AW - DW);

    function automatic logic [AW-1:0] scaled_mag(input logic signed [DW-1:0] s);
        logic [DW-1:0] m;
        if (s == {1'b1, {(DW-1){1'b0}}}) m = {1'b0, {(DW-1){1'b1}}};
        else if (s[DW-1])                m = -s;
        else                             m = s;
        return AW'(m) << (AW - DW);
    endfunction

    AST_VLD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld_o |-> $past(smp_en_i)); // R6

    AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld_o |-> $stable(result_o)); // R4

    AST_LEAKY_EVERY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_en_i) && $past(mode_i)) |-> result_vld_o); // R10

    AST_LEAKY_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld_o && $past(mode_i)) |-> (result_o <= Y_CEIL)); // R7

    AST_K0_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (result_vld_o && $past(mode_i) && ($past(leak_sel_i) == 2'd0))
        |-> (result_o == scaled_mag($past(smp_i)))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (!result_vld_o && (result_o == '0))); // R1
endmodule

bind sig_level_meter lvlm_chk #(.DW(DW), .AW(AW)) u_lvlm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_i        (smp_i),
    .smp_en_i     (smp_en_i),
    .mode_i       (mode_i),
    .leak_sel_i   (leak_sel_i),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
);

// File: tb/test_sig_level_meter.sv
module test_sig_level_meter;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n = 1'b0;
    logic signed [15:0] smp   = '0;
    logic               en    = 1'b0;
    logic               mode  = 1'b0;
    logic [1:0]         sel   = '0;
    logic [15:0]        win   = '0;
    logic [31:0]        res;
    logic               vld;

    sig_level_meter i_sig_level_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_i        (smp),
        .smp_en_i     (en),
        .mode_i       (mode),
        .leak_sel_i   (sel),
        .win_len_i    (win),
        .result_o     (res),
        .result_vld_o (vld)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    longint m_acc = 0;
    longint m_res = 0;
    longint m_cnt = 0;
    bit     m_vld = 0;
    bit     m_mode = 0;

    function automatic longint magf(input logic signed [15:0] s);
        if (s == -16'sd32768) return 32767;
        if (s < 0) return -longint'(s);
        return longint'(s);
    endfunction

    function automatic int kof(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 8;
            2'd2: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_res = 0; m_cnt = 0; m_vld = 0; m_mode = 0;
        end else begin
            m_vld = 0;
            if (mode != m_mode) begin
                m_acc = 0; m_cnt = 0; m_mode = mode;
            end
            if (en) begin
                if (!mode) begin
                    m_acc += magf(smp);
                    m_cnt++;
                    if (m_cnt >= longint'(win) + 2) begin
                        m_res = m_acc; m_vld = 1; m_acc = 0; m_cnt = 0;
                    end
                end else begin
                    m_acc = m_acc + ((magf(smp) * 65536) >>> kof(sel)) - (m_acc >>> kof(sel));
                    m_res = m_acc;
                    m_vld = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, longint'(res), m_res);
            chk(cur_req, longint'(vld), longint'(m_vld));
        end
    end

    task automatic put(input logic signed [15:0] s, input logic e);
        @(negedge clk);
        smp = s;
        en  = e;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", longint'(res), 0);
        chk("R1", longint'(vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", longint'(res), 0);
        chk("R1", longint'(vld), 0);

        // R5, R2: two-sample window with most negative code
        cur_req = "R2";
        win = 16'd0;
        put(-16'sd32768, 1'b1);
        put(16'sd5, 1'b1);
        @(negedge clk); en = 1'b0;
        chk("R5", longint'(res), 32772);
        chk("R2", longint'(vld), 1);
        @(negedge clk);
        chk("R4", longint'(vld), 0);
        chk("R4", longint'(res), 32772);

        // R4: next window restarts from zero
        cur_req = "R4";
        put(16'sd100, 1'b1);
        put(-16'sd100, 1'b1);
        @(negedge clk); en = 1'b0;
        chk("R4", longint'(res), 200);

        // R6: gaps with large ignored values
        cur_req = "R6";
        win = 16'd3;
        for (int i = 1; i <= 5; i++) begin
            put(16'sd30000, 1'b0);
            put(16'(i), 1'b1);
        end
        @(negedge clk); en = 1'b0;
        chk("R6", longint'(res), 15);
        chk("R6", longint'(vld), 1);

        // R2/R6: random enables and samples
        cur_req = "R2";
        win = 16'($urandom_range(0, 5));
        for (int i = 0; i < 400; i++) begin
            put(16'($urandom), 1'($urandom_range(0, 1)));
        end
        put(16'sd0, 1'b0);
        repeat (2) put(16'sd0, 1'b0);

        // R3: longest window of saturated samples
        cur_req = "R3";
        mode = 1'b1; put(16'sd0, 1'b0);
        mode = 1'b0; put(16'sd0, 1'b0);
        win = 16'hFFFF;
        for (int i = 0; i < 65537; i++) put(-16'sd32768, 1'b1);
        @(negedge clk); en = 1'b0;
        chk("R3", longint'(res), 64'd65537 * 64'd32767);
        chk("R3", longint'(vld), 1);

        // R9: switch to smoothing two samples into a window
        cur_req = "R9";
        win = 16'd3;
        put(16'sd10, 1'b1);
        put(16'sd10, 1'b1);
        @(negedge clk);
        mode = 1'b1; sel = 2'd0; smp = 16'sd3; en = 1'b1;
        @(negedge clk); en = 1'b0;
        chk("R8", longint'(res), 196608);
        chk("R9", longint'(vld), 1);

        // R7: k = 8 step from a known state
        cur_req = "R7";
        sel = 2'd1;
        put(16'sd256, 1'b1);
        @(negedge clk); en = 1'b0;
        chk("R7", longint'(res), 261376);

        // R8/R10: k = 16 settling and random selections
        cur_req = "R8";
        sel = 2'd3;
        for (int i = 0; i < 300; i++) put(16'sd1000, 1'b1);
        cur_req = "R10";
        for (int i = 0; i < 2000; i++) begin
            sel = 2'($urandom_range(0, 3));
            win = 16'($urandom);
            put(16'($urandom), 1'($urandom_range(0, 9) < 7));
        end

        // R9: back to windowed mode mid-stream
        cur_req = "R9";
        @(negedge clk);
        mode = 1'b0; win = 16'd0; smp = 16'sd7; en = 1'b1;
        put(16'sd8, 1'b1);
        @(negedge clk); en = 1'b0;
        chk("R9", longint'(res), 15);
        chk("R9", longint'(vld), 1);
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule